// File: doc/BRIEF.md
# Latched Status Event Register Set

This block is one status register set of an instrument's remote-control status structure. It watches a vector of live condition inputs. A rising edge on any condition bit is caught in a sticky event register. That bit stays at 1 until the host reads the event register or a clear-status strobe arrives. A host-programmed enable register selects which event bits count. The masked event bits are ORed into one registered summary output. That output drives one bit of a higher-level status byte.

The host reaches the set through a small register port. It has a 2-bit address, one-cycle read and write strobes, a write data bus and a registered read data bus. The address encoding is 0 for the condition register, 1 for the event register, 2 for the enable register and 3 unused. A read of address 1 returns the event bits and clears them in the same step. A preset strobe is also accepted. It changes nothing in this set.

Top module: `sts_event_set`

## Requirements
- R1: After synchronous reset, the event register, enable register, read data and summary output are all 0. The delayed condition copy is also 0, so a condition bit that is 1 when reset ends counts as a rising edge.
- R2: When a condition bit goes from 0 to 1, the matching event bit is 1 after the next clock edge. The bit stays 1 when the condition later falls, and until a clear.
- R3: A read strobe at address 1 loads the event register into the read data and clears the event register. If a condition bit rises in that same cycle, its event bit is still 1 afterwards.
- R4: A clear-status strobe clears every event bit, except a bit whose condition rises in that same cycle. It leaves the enable register unchanged.
- R5: A preset strobe changes neither the event register nor the enable register.
- R6: A write strobe at address 2 loads the write data into the enable register. Writing 0 clears every enable bit. A read at address 2 returns the enable value.
- R7: A read at address 0 returns the live condition inputs of that cycle, and it neither latches nor clears anything.
- R8: The summary output is registered. One cycle after any bit is 1 in both the event and enable registers it is 1, and otherwise it is 0.
- R9: The read data changes only on the clock edge that samples a read strobe and holds otherwise. A read at address 3 returns 0. Write strobes at addresses 0, 1 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | WIDTH | Live condition inputs |
| clr_status_i | input | 1 | Clear-status strobe, clears events |
| preset_i | input | 1 | Preset strobe, no effect on this set |
| host_addr_i | input | 2 | Register select: 0 condition, 1 event, 2 enable, 3 unused |
| host_rd_i | input | 1 | One-cycle read strobe |
| host_wr_i | input | 1 | One-cycle write strobe |
| host_wdata_i | input | WIDTH | Write data |
| host_rdata_o | output | WIDTH | Registered read data |
| summary_o | output | 1 | Registered OR of enabled event bits |

## Verification
The assertions assume that reset is applied for at least one clock before the properties are used. They also assume that the host strobes and the condition inputs are synchronous to the clock. Read and write strobes may arrive together and in any cycle. The bench drives every input on the falling edge, so all of them are stable when the rising edge samples them. Random stimulus covers any mix of strobes and addresses in each cycle. The clear-status strobe is weighted low so that event bits can build up between clears. Condition bits toggle sparsely, so both rising and falling edges occur.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_COND = 2'd0,
    SEL_EVT  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sts_edge_detect.sv
module sts_edge_detect #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cond_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] cond_q;

  always_ff @(posedge clk) begin
    if (rst) cond_q <= '0;
    else     cond_q <= cond_i;
  end

  assign rise_o = cond_i & ~cond_q;

  // R2: a rise is reported only when the input was low on the previous cycle
  p_rise_from_low_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rise_o & $past(cond_i)) == '0));
endmodule

// File: rtl/sts_event_latch.sv
module sts_event_latch #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rise_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] evt_o
);
  logic [WIDTH-1:0] evt_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            evt_q[b] <= 1'b0;
      else if (clr_i)     evt_q[b] <= rise_i[b];
      else if (rise_i[b]) evt_q[b] <= 1'b1;
    end
  end

  assign evt_o = evt_q;

  // R2: without a clear, a set bit stays set
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
  // R2: a rise always lands in the register
  p_rise_lands_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evt_q & $past(rise_i)) == $past(rise_i)));
  // R3 / R4: after a clear only same-cycle rises remain
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> ((evt_q & ~$past(rise_i)) == '0));
endmodule

// File: rtl/sts_enable_reg.sv
module sts_enable_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] en_o
);
  logic [WIDTH-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst)       en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end

  assign en_o = en_q;

  p_en_load_r6: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (en_q == $past(wdata_i)));
  // R4 / R5: only a host write moves the mask
  p_en_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(en_q));
endmodule

// File: rtl/sts_readback.sv
module sts_readback
  import sts_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_i,
  input  reg_sel_e         sel_i,
  input  logic [WIDTH-1:0] cond_i,
  input  logic [WIDTH-1:0] evt_i,
  input  logic [WIDTH-1:0] en_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mux_d;
  logic [WIDTH-1:0] rdata_q;

  always_comb begin
    unique case (sel_i)
      SEL_COND: mux_d = cond_i;
      SEL_EVT:  mux_d = evt_i;
      SEL_EN:   mux_d = en_i;
      default:  mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= mux_d;
  end

  assign rdata_o = rdata_q;

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_q));
  p_rd_none_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_i && sel_i == SEL_NONE) |=> (rdata_q == '0));
  p_rd_cond_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_i && sel_i == SEL_COND) |=> (rdata_q == $past(cond_i)));
endmodule

// File: rtl/sts_event_set.sv
module sts_event_set
  import sts_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  cond_i,
  input  logic              clr_status_i,
  input  logic              preset_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [WIDTH-1:0]  host_wdata_i,
  output logic [WIDTH-1:0]  host_rdata_o,
  output logic              summary_o
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] rise;
  logic [WIDTH-1:0] evt;
  logic [WIDTH-1:0] en;
  logic             evt_clr;
  logic             en_wr;
  logic             summary_q;

  assign sel     = reg_sel_e'(host_addr_i);
  assign evt_clr = clr_status_i | (host_rd_i & (sel == SEL_EVT));
  assign en_wr   = host_wr_i & (sel == SEL_EN);

  sts_edge_detect #(.WIDTH(WIDTH)) u_edge (
    .clk(clk), .rst(rst), .cond_i(cond_i), .rise_o(rise)
  );

  sts_event_latch #(.WIDTH(WIDTH)) u_evt (
    .clk(clk), .rst(rst), .rise_i(rise), .clr_i(evt_clr), .evt_o(evt)
  );

  sts_enable_reg #(.WIDTH(WIDTH)) u_en (
    .clk(clk), .rst(rst), .wr_i(en_wr), .wdata_i(host_wdata_i), .en_o(en)
  );

  sts_readback #(.WIDTH(WIDTH)) u_rb (
    .clk(clk), .rst(rst), .rd_i(host_rd_i), .sel_i(sel),
    .cond_i(cond_i), .evt_i(evt), .en_i(en), .rdata_o(host_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) summary_q <= 1'b0;
    else     summary_q <= |(evt & en);
  end

  assign summary_o = summary_q;

  p_summary_off_r8: assert property (@(posedge clk) disable iff (rst)
    ((evt & en) == '0) |=> !summary_o);
  p_summary_on_r8: assert property (@(posedge clk) disable iff (rst)
    ((evt & en) != '0) |=> summary_o);
  // R5: preset alone leaves the events untouched
  p_preset_evt_r5: assert property (@(posedge clk) disable iff (rst)
    (preset_i && !evt_clr && rise == '0) |=> $stable(evt));
endmodule

// File: tb/sts_event_set_bench.sv
`timescale 1ns/1ps
module sts_event_set_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] cond;
  logic         clr, pre, rd, wr;
  logic [1:0]   addr;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata;
  logic         summary;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] m_condq, m_evt, m_en, m_rdata;
  logic         m_sum;

  always #5 clk = ~clk;

  sts_event_set #(.WIDTH(W)) u_sts_event_set (
    .clk(clk), .rst(rst), .cond_i(cond), .clr_status_i(clr), .preset_i(pre),
    .host_addr_i(addr), .host_rd_i(rd), .host_wr_i(wr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .summary_o(summary)
  );

  function automatic logic [W-1:0] pick(logic [1:0] a, logic [W-1:0] c,
                                        logic [W-1:0] e, logic [W-1:0] n);
    case (a)
      2'd0: return c;
      2'd1: return e;
      2'd2: return n;
      default: return '0;
    endcase
  endfunction

  task automatic model_reset();
    m_condq = '0; m_evt = '0; m_en = '0; m_rdata = '0; m_sum = 1'b0;
  endtask

  task automatic model_step();
    logic [W-1:0] rise;
    logic [W-1:0] nevt;
    rise = cond & ~m_condq;
    if (clr || (rd && addr == 2'd1)) nevt = rise;
    else                             nevt = m_evt | rise;
    if (rd) m_rdata = pick(addr, cond, m_evt, m_en);
    m_sum = |(m_evt & m_en);
    if (wr && addr == 2'd2) m_en = wdata;
    m_evt   = nevt;
    m_condq = cond;
  endtask

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    clr = 0; pre = 0; rd = 0; wr = 0; addr = 2'd0; wdata = '0;
  endtask

  // one clock: inputs already set at the falling edge; compare after next falling edge
  task automatic step(string rq_data, string rq_sum);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(rq_data, "rdata", rdata, m_rdata);
    check(rq_sum, "summary", {{(W-1){1'b0}}, summary}, {{(W-1){1'b0}}, m_sum});
  endtask

  task automatic host_read(logic [1:0] a, string rq);
    idle(); rd = 1; addr = a;
    step(rq, "R8");
    idle();
  endtask

  task automatic host_write(logic [1:0] a, logic [W-1:0] d, string rq);
    idle(); wr = 1; addr = a; wdata = d;
    step(rq, "R8");
    idle();
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(); cond = '0; rst = 1;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state visible at the ports
    check("R1", "rdata after reset", rdata, '0);
    check("R1", "summary after reset", {{(W-1){1'b0}}, summary}, '0);
    host_read(2'd1, "R1");
    host_read(2'd2, "R1");

    // R2: rise then fall, bit stays latched
    cond = 16'h0005; step("R2", "R8");
    cond = 16'h0000; step("R2", "R8");
    host_write(2'd2, 16'hffff, "R6");
    step("R2", "R8");
    check("R8", "summary enabled event", {{(W-1){1'b0}}, summary}, 16'h0001);
    // R3: read returns and clears
    host_read(2'd1, "R3");
    check("R3", "event read value", rdata, 16'h0005);
    host_read(2'd1, "R3");
    check("R3", "event cleared", rdata, 16'h0000);

    // R3: rise in the read cycle survives
    idle(); rd = 1; addr = 2'd1; cond = 16'h0100; step("R3", "R8");
    idle();
    host_read(2'd1, "R3");
    check("R3", "collision survives", rdata, 16'h0100);

    // R4: clear-status keeps enable, keeps same-cycle rise
    cond = 16'h0300; step("R4", "R8");
    idle(); clr = 1; cond = 16'h0b00; step("R4", "R8");
    idle();
    host_read(2'd1, "R4");
    check("R4", "clear keeps coincident rise", rdata, 16'h0800);
    host_read(2'd2, "R4");
    check("R4", "enable kept", rdata, 16'hffff);

    // R5: preset touches nothing
    cond = 16'h1b00; step("R5", "R8");
    idle(); pre = 1; step("R5", "R8");
    idle();
    host_read(2'd1, "R5");
    check("R5", "events after preset", rdata, 16'h1000);
    host_read(2'd2, "R5");
    check("R5", "enable after preset", rdata, 16'hffff);

    // R6: writing 0 clears enable; summary drops
    cond = 16'h3b00; step("R6", "R8");
    host_write(2'd2, '0, "R6");
    host_read(2'd2, "R6");
    check("R6", "enable zeroed", rdata, 16'h0000);
    check("R8", "summary masked", {{(W-1){1'b0}}, summary}, 16'h0000);

    // R7: live condition read
    cond = 16'habcd; host_read(2'd0, "R7");
    check("R7", "condition value", rdata, 16'habcd);

    // R9: unused address and ignored writes
    host_read(2'd3, "R9");
    check("R9", "unused address", rdata, 16'h0000);
    host_write(2'd1, 16'hffff, "R9");
    host_write(2'd0, 16'hffff, "R9");
    host_write(2'd3, 16'hffff, "R9");
    host_read(2'd2, "R9");
    check("R9", "enable after stray writes", rdata, 16'h0000);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      clr   = ($urandom_range(0, 19) == 0);
      pre   = ($urandom_range(0, 9) == 0);
      rd    = ($urandom_range(0, 2) == 0);
      wr    = ($urandom_range(0, 4) == 0);
      addr  = 2'($urandom_range(0, 3));
      wdata = W'($urandom());
      cond  = cond ^ (W'($urandom()) & W'($urandom()) & W'($urandom()));
      step("R9", "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule